// File: doc/BRIEF.md
# EPROM Program-Verify Sequencer

This block sits on the programmer side of a byte-wide UV-erasable EPROM. It writes a data image into the device using an adaptive pulse-and-check loop. After a start request it visits every address in ascending order. For each address it fetches the target byte from a small image source. It then applies fixed-width program pulses and reads the byte back after each one. It stops pulsing as soon as the byte reads back correctly, or once a per-byte pulse cap is reached. While it works through the addresses it requests raised supply levels for the core and for programming. After the last address it drops that request and reads the whole array once more at nominal supply, comparing each byte with the image.

The block works in the erased-is-one model: a pulse can only clear bits. A target byte that needs a bit raised from 0 to 1 can therefore never verify, and the byte ends in a failure at the pulse cap. Target bytes of FFh already match an erased cell, so they get no pulses. Any failure stops the run, raises `error` and holds the offending address. A clean run raises `done`.

The state machine has eight states:
- IDLE: waits for `start`.
- FETCH: latches the target byte.
- PULSE: the program pulse.
- PVFY: the per-pulse read-back.
- NEXT: steps to the following address.
- FINAL: the nominal-supply array check.
- DONE and FAIL: the two terminal states.

Its transitions are:
- start: from IDLE, DONE or FAIL to FETCH.
- skip: FETCH to NEXT, for an FFh target.
- fire: FETCH to PULSE.
- pulse end: PULSE to PVFY.
- match: PVFY to NEXT.
- retry: PVFY back to PULSE.
- cap: PVFY to FAIL.
- advance: NEXT to FETCH.
- last: NEXT to FINAL.
- final mismatch: FINAL to FAIL.
- final clean: FINAL to DONE.

Top module: `eprom_prog_seq`

## Requirements
- R1: `start` sampled high in IDLE, DONE or FAIL begins a run at address 0. `busy` is high from the next cycle until `done` or `error` rises. `start` while `busy` is high has no effect. `busy`, `done` and `error` are never high two at a time.
- R2: A program pulse drives `dev_sel_n`=0, `dev_prog_n`=0, `dev_rd_n`=1, `dev_wdata_oe`=1 and `supply_raise`=1. It presents the target byte on `dev_wdata` for exactly PULSE_CYCLES cycles.
- R3: After every pulse the block reads the byte with `dev_sel_n`=0, `dev_rd_n`=0 and `dev_prog_n`=1 for RD_CYCLES cycles, and compares `dev_rdata` in the last of them. On a match it moves on to the next address. On a mismatch below the cap it applies another pulse.
- R4: Each address receives exactly as many pulses as it takes to read back correctly. `pulse_cnt` shows the number of pulses applied to the current byte.
- R5: If a byte still mismatches after MAX_PULSES pulses, the run ends with `error`=1 and `fail_addr` equal to that address. `pulse_cnt` then equals MAX_PULSES, and no later address receives any pulse.
- R6: An address whose image byte is 8'hFF receives no pulse.
- R7: Addresses are programmed in ascending order from 0 to 2^ADDR_W-1.
- R8: After the last address, every address is read once at nominal supply (`supply_raise`=0, `dev_sel_n`=0, `dev_rd_n`=0) for RD_CYCLES cycles. If every byte equals the image, `done` rises.
- R9: A byte that differs from the image in the final pass ends the run with `error`=1 and `fail_addr` equal to that address.
- R10: A target byte that would need a bit set from 0 to 1 never verifies, so it fails as in R5.
- R11: While `rst_n` is low, and after its release, the outputs are idle: `busy`=`done`=`error`=0, `dev_sel_n`=`dev_rd_n`=`dev_prog_n`=1, `dev_wdata_oe`=0 and `supply_raise`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a programming run |
| src_addr | output | ADDR_W | Image source address |
| src_data | input | 8 | Image byte at `src_addr`, valid in the same cycle |
| dev_addr | output | ADDR_W | Device address |
| dev_wdata | output | 8 | Byte driven to the device during a pulse |
| dev_wdata_oe | output | 1 | Enable for the programmer's data drivers |
| dev_rdata | input | 8 | Byte read from the device |
| dev_sel_n | output | 1 | Device chip select, active low |
| dev_rd_n | output | 1 | Device output enable, active low |
| dev_prog_n | output | 1 | Device program strobe, active low |
| supply_raise | output | 1 | Request for raised core and programming supplies |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished with every byte verified |
| error | output | 1 | Run stopped on a failure |
| fail_addr | output | ADDR_W | Address of the failure |
| pulse_cnt | output | $clog2(MAX_PULSES+1) | Pulses applied to the current byte |

## Verification
The device outputs are decoded from the state register, so a pulse or read phase is visible on the pins in the cycle after the edge that enters its state. A pulse therefore shows as a run of exactly PULSE_CYCLES sampled cycles with the program strobe low. `done` and `error` rise one cycle after the deciding comparison and then hold. The bench samples every pin on the falling edge and applies device programming when the strobe returns high. It waits for the terminal flags at the level instead of counting cycles, which keeps the results independent of the number of pulses per byte.

// File: rtl/eprom_seq_pkg.sv
package eprom_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH,
        S_PULSE,
        S_PVFY,
        S_NEXT,
        S_FINAL,
        S_DONE,
        S_FAIL
    } seq_state_t;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/epv_timer.sv
module epv_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R2: an expired timer stays expired until it is reloaded
    p_timer_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && expired) |=> expired);

endmodule

// File: rtl/epv_addr_gen.sv
module epv_addr_gen #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [AW-1:0] addr,
    output logic          last
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr <= '0;
        else if (clr)
            addr <= '0;
        else if (inc)
            addr <= addr + 1'b1;
    end

    assign last = (addr == {AW{1'b1}});

    // R7: an increment moves exactly one step upward
    p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && !last) |=> (addr == $past(addr) + 1'b1));

endmodule

// File: rtl/epv_pulse_ctr.sv
module epv_pulse_ctr #(
    parameter int MAXP = 25,
    parameter int PCW  = $clog2(MAXP + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           inc,
    output logic [PCW-1:0] cnt,
    output logic           at_cap
);

    localparam logic [PCW-1:0] CAP = PCW'(MAXP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc && !at_cap)
            cnt <= cnt + 1'b1;
    end

    assign at_cap = (cnt == CAP);

    // R5: the per-byte count never passes the cap
    p_cap_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CAP);

endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
    import eprom_seq_pkg::*;
#(
    parameter int ADDR_W       = 17,
    parameter int PULSE_CYCLES = 10000,
    parameter int RD_CYCLES    = 4,
    parameter int MAX_PULSES   = 25
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    output logic [ADDR_W-1:0]                 src_addr,
    input  logic [7:0]                        src_data,
    output logic [ADDR_W-1:0]                 dev_addr,
    output logic [7:0]                        dev_wdata,
    output logic                              dev_wdata_oe,
    input  logic [7:0]                        dev_rdata,
    output logic                              dev_sel_n,
    output logic                              dev_rd_n,
    output logic                              dev_prog_n,
    output logic                              supply_raise,
    output logic                              busy,
    output logic                              done,
    output logic                              error,
    output logic [ADDR_W-1:0]                 fail_addr,
    output logic [$clog2(MAX_PULSES+1)-1:0]   pulse_cnt
);

    localparam int TMAX = (PULSE_CYCLES > RD_CYCLES) ? PULSE_CYCLES : RD_CYCLES;
    localparam int TW   = $clog2(TMAX) + 1;
    localparam int PCW  = $clog2(MAX_PULSES + 1);
    localparam logic [TW-1:0] PULSE_LD = TW'(PULSE_CYCLES - 1);
    localparam logic [TW-1:0] RD_LD    = TW'(RD_CYCLES - 1);

    seq_state_t st_q, st_d;
    logic [7:0]        tgt_q;
    logic [ADDR_W-1:0] fail_q;
    logic [ADDR_W-1:0] addr;
    logic              a_clr, a_inc, a_last;
    logic              p_clr, p_inc, p_cap;
    logic              tmr_ld, tmr_exp;
    logic [TW-1:0]     tmr_val;
    logic              tgt_ld, fail_ld;

    epv_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_ld),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    epv_addr_gen #(.AW(ADDR_W)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (a_clr),
        .inc   (a_inc),
        .addr  (addr),
        .last  (a_last)
    );

    epv_pulse_ctr #(.MAXP(MAX_PULSES), .PCW(PCW)) u_pulses (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (p_clr),
        .inc    (p_inc),
        .cnt    (pulse_cnt),
        .at_cap (p_cap)
    );

    // state register and datapath latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            tgt_q  <= ERASED_BYTE;
            fail_q <= '0;
        end else begin
            st_q <= st_d;
            if (tgt_ld)
                tgt_q <= src_data;
            if (fail_ld)
                fail_q <= addr;
        end
    end

    // next state and sequencing strobes
    always_comb begin
        st_d    = st_q;
        tmr_ld  = 1'b0;
        tmr_val = '0;
        a_clr   = 1'b0;
        a_inc   = 1'b0;
        p_clr   = 1'b0;
        p_inc   = 1'b0;
        tgt_ld  = 1'b0;
        fail_ld = 1'b0;
        unique case (st_q)
            S_IDLE, S_DONE, S_FAIL: begin
                if (start) begin
                    st_d  = S_FETCH;
                    a_clr = 1'b1;
                    p_clr = 1'b1;
                end
            end
            S_FETCH: begin
                tgt_ld = 1'b1;
                p_clr  = 1'b1;
                if (src_data == ERASED_BYTE) begin
                    st_d = S_NEXT;
                end else begin
                    st_d    = S_PULSE;
                    tmr_ld  = 1'b1;
                    tmr_val = PULSE_LD;
                end
            end
            S_PULSE: begin
                if (tmr_exp) begin
                    st_d    = S_PVFY;
                    p_inc   = 1'b1;
                    tmr_ld  = 1'b1;
                    tmr_val = RD_LD;
                end
            end
            S_PVFY: begin
                if (tmr_exp) begin
                    if (dev_rdata == tgt_q) begin
                        st_d = S_NEXT;
                    end else if (p_cap) begin
                        st_d    = S_FAIL;
                        fail_ld = 1'b1;
                    end else begin
                        st_d    = S_PULSE;
                        tmr_ld  = 1'b1;
                        tmr_val = PULSE_LD;
                    end
                end
            end
            S_NEXT: begin
                if (a_last) begin
                    st_d    = S_FINAL;
                    a_clr   = 1'b1;
                    tmr_ld  = 1'b1;
                    tmr_val = RD_LD;
                end else begin
                    st_d  = S_FETCH;
                    a_inc = 1'b1;
                end
            end
            S_FINAL: begin
                if (tmr_exp) begin
                    if (dev_rdata != src_data) begin
                        st_d    = S_FAIL;
                        fail_ld = 1'b1;
                    end else if (a_last) begin
                        st_d = S_DONE;
                    end else begin
                        a_inc   = 1'b1;
                        tmr_ld  = 1'b1;
                        tmr_val = RD_LD;
                    end
                end
            end
        endcase
    end

    // Moore outputs decoded from the state
    always_comb begin
        dev_sel_n    = 1'b1;
        dev_rd_n     = 1'b1;
        dev_prog_n   = 1'b1;
        dev_wdata_oe = 1'b0;
        supply_raise = 1'b0;
        busy         = 1'b1;
        done         = 1'b0;
        error        = 1'b0;
        unique case (st_q)
            S_IDLE:  busy = 1'b0;
            S_DONE: begin
                busy = 1'b0;
                done = 1'b1;
            end
            S_FAIL: begin
                busy  = 1'b0;
                error = 1'b1;
            end
            S_FETCH, S_NEXT: supply_raise = 1'b1;
            S_PULSE: begin
                supply_raise = 1'b1;
                dev_sel_n    = 1'b0;
                dev_prog_n   = 1'b0;
                dev_wdata_oe = 1'b1;
            end
            S_PVFY: begin
                supply_raise = 1'b1;
                dev_sel_n    = 1'b0;
                dev_rd_n     = 1'b0;
            end
            S_FINAL: begin
                dev_sel_n = 1'b0;
                dev_rd_n  = 1'b0;
            end
        endcase
    end

    assign src_addr  = addr;
    assign dev_addr  = addr;
    assign dev_wdata = tgt_q;
    assign fail_addr = fail_q;

    // R2: a program strobe only with reads off, data driven and supplies raised
    p_pulse_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_prog_n |-> (!dev_sel_n && dev_rd_n && dev_wdata_oe && supply_raise));

    // R3: any read has the strobe off and the data drivers released
    p_read_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_rd_n |-> (dev_prog_n && !dev_sel_n && !dev_wdata_oe));

    // R1: status flags are mutually exclusive
    p_status_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({busy, done, error}) <= 1);

    // R5: a failure after a pulse read-back happens only at the cap
    p_fail_at_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(error) && supply_raise == 1'b0 && $past(!dev_rd_n && supply_raise))
            |-> (pulse_cnt == PCW'(MAX_PULSES)));

    // R8: the device is deselected and supplies nominal once finished
    p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (dev_sel_n && !supply_raise));

endmodule

// File: tb/eprom_prog_seq_test.sv
module eprom_prog_seq_test;

    localparam int AW  = 4;
    localparam int N   = 16;
    localparam int PC  = 20;
    localparam int RD  = 2;
    localparam int MP  = 4;
    localparam int PCW = $clog2(MP + 1);

    // {image byte, pulses the cell needs, expected pulses in a clean run}
    localparam logic [15:0] VEC [N] = '{
        16'hA511, 16'h3C22, 16'h0044, 16'hFF00,
        16'h8111, 16'h7E33, 16'hFF00, 16'h1222,
        16'h0011, 16'h5A11, 16'hC344, 16'hFE22,
        16'h0133, 16'hFF00, 16'h9611, 16'h6922
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] src_addr, dev_addr, fail_addr;
    logic [7:0] src_data, dev_wdata, dev_rdata;
    logic dev_wdata_oe, dev_sel_n, dev_rd_n, dev_prog_n, supply_raise;
    logic busy, done, error;
    logic [PCW-1:0] pulse_cnt;

    logic [7:0] img [N];
    logic [7:0] mem [N];
    int need [N];
    int seen [N];
    int pcount [N];
    int run_len, width_bad, order_bad, last_pa, final_reads, supply_bad;
    bit prev_prog;
    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    eprom_prog_seq #(
        .ADDR_W(AW), .PULSE_CYCLES(PC), .RD_CYCLES(RD), .MAX_PULSES(MP)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_addr(src_addr), .src_data(src_data),
        .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_wdata_oe(dev_wdata_oe),
        .dev_rdata(dev_rdata), .dev_sel_n(dev_sel_n), .dev_rd_n(dev_rd_n),
        .dev_prog_n(dev_prog_n), .supply_raise(supply_raise),
        .busy(busy), .done(done), .error(error),
        .fail_addr(fail_addr), .pulse_cnt(pulse_cnt)
    );

    assign src_data  = img[src_addr];
    assign dev_rdata = (!dev_sel_n && !dev_rd_n) ? mem[dev_addr] : 8'hFF;

    // device model and pin monitor, on the falling edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (!dev_prog_n) begin
                run_len = run_len + 1;
                if (!supply_raise) supply_bad = supply_bad + 1;
            end
            if (!prev_prog && dev_prog_n) begin
                if (run_len != PC) width_bad = width_bad + 1;
                run_len = 0;
                if (int'(dev_addr) < last_pa) order_bad = order_bad + 1;
                last_pa = int'(dev_addr);
                pcount[dev_addr] = pcount[dev_addr] + 1;
                seen[dev_addr] = seen[dev_addr] + 1;
                if (seen[dev_addr] >= need[dev_addr])
                    mem[dev_addr] = mem[dev_addr] & dev_wdata;
            end
            if (!dev_sel_n && !dev_rd_n && !supply_raise)
                final_reads = final_reads + 1;
        end
        prev_prog = dev_prog_n;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic prep();
        for (int i = 0; i < N; i++) begin
            img[i]    = VEC[i][15:8];
            need[i]   = int'(VEC[i][7:4]);
            mem[i]    = 8'hFF;
            seen[i]   = 0;
            pcount[i] = 0;
        end
        run_len = 0; width_bad = 0; order_bad = 0; last_pa = 0;
        final_reads = 0; supply_bad = 0;
    endtask

    task automatic go();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_end(input string req);
        int n;
        n = 0;
        while (!(done || error) && n < 30000) begin
            @(negedge clk);
            n = n + 1;
        end
        chk(n < 30000, {req, " watchdog"}, n, 30000);
    endtask

    task automatic check_idle(input string req);
        chk(!busy && !done && !error, req, {busy, done, error}, 0);
        chk(dev_sel_n && dev_rd_n && dev_prog_n, req,
            {dev_sel_n, dev_rd_n, dev_prog_n}, 7);
        chk(!dev_wdata_oe && !supply_raise, req, {dev_wdata_oe, supply_raise}, 0);
    endtask

    initial begin
        int later;
        prep();
        prev_prog = 1'b1;
        repeat (3) @(negedge clk);
        check_idle("R11 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R11 after reset");

        // run A: clean image walked from the vector table; start pulsed mid-run
        go();
        chk(busy, "R1 busy after start", busy, 1);
        repeat (100) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_end("R1 run A");
        chk(done && !error && !busy, "R8 clean run done", {busy, done, error}, 2);
        for (int i = 0; i < N; i++) begin
            chk(pcount[i] == int'(VEC[i][3:0]),
                (VEC[i][15:8] == 8'hFF) ? "R6 FF skipped" : "R4 pulses per byte",
                pcount[i], int'(VEC[i][3:0]));
            chk(mem[i] == img[i], "R3 byte programmed", mem[i], img[i]);
        end
        chk(width_bad == 0, "R2 pulse width", width_bad, 0);
        chk(supply_bad == 0, "R2 raised supply", supply_bad, 0);
        chk(order_bad == 0, "R7 ascending order", order_bad, 0);
        chk(final_reads == N * RD, "R8 final pass reads", final_reads, N * RD);

        // run B: a stubborn byte at address 5 hits the cap; restart from DONE
        prep();
        need[5] = MP + 1;
        go();
        wait_end("R5 run B");
        chk(error && !done && !busy, "R5 error flag", {busy, done, error}, 1);
        chk(fail_addr == 4'd5, "R5 fail address", fail_addr, 5);
        chk(pulse_cnt == PCW'(MP), "R5 pulse count at cap", pulse_cnt, MP);
        chk(pcount[5] == MP, "R5 pulses on failing byte", pcount[5], MP);
        later = 0;
        for (int i = 6; i < N; i++) later = later + pcount[i];
        chk(later == 0, "R5 no later pulses", later, 0);
        chk(final_reads == 0, "R5 no final pass", final_reads, 0);

        // run C: cell at 9 holds zeros where the image has ones
        prep();
        mem[9] = 8'h0F;
        go();
        wait_end("R10 run C");
        chk(error && !done, "R10 error flag", {done, error}, 1);
        chk(fail_addr == 4'd9, "R10 fail address", fail_addr, 9);
        chk(pcount[9] == MP, "R10 pulses to cap", pcount[9], MP);

        // run D: skipped FF byte at 3 has a cleared bit; found in final pass
        prep();
        mem[3] = 8'hFE;
        go();
        wait_end("R9 run D");
        chk(error && !done, "R9 error flag", {done, error}, 1);
        chk(fail_addr == 4'd3, "R9 fail address", fail_addr, 3);
        chk(pcount[3] == 0, "R6 no pulse on FF", pcount[3], 0);
        chk(mem[15] == img[15], "R9 last byte programmed", mem[15], img[15]);
        chk(final_reads == 4 * RD, "R9 final reads up to fault", final_reads, 4 * RD);

        // reset in the middle of a run
        prep();
        go();
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("R11 reset mid-run");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R11 release mid-run");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule